// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands and returns a 32-bit product. Operands come in over a valid/ready handshake and results go out over a second one. Inside, two register stages sit between them. The first stage unpacks and classifies both operands, forms the 48-bit significand product and sums the exponents. The second stage normalizes, rounds and packs the result, and holds it until the consumer takes it.

A per-operation mode bit travels with each operand pair. With the bit clear, the block rounds to nearest and breaks ties away from zero. With the bit set, it truncates toward zero. The block flushes subnormal inputs to zero and keeps their sign, and it never emits a subnormal. Exceptional cases show up only in the returned value: NaN, signed infinity or signed zero.

Top module: `fp32_mul_unit`

## Requirements
- R1: With `rnd_trunc`=0, a product that lies exactly halfway between two representable values rounds to the one of larger magnitude, and a product below half an ulp rounds down (1.5 × 0x3F800001 gives 0x3FC00002).
- R2: With `rnd_trunc`=1, the discarded bits are always dropped, so the magnitude is never increased (1.5 × 0x3F800001 gives 0x3FC00001).
- R3: When rounding carries the significand up to 2.0, the mantissa field becomes zero and the exponent goes up by one (0x3FFFF800 × 0x3F800400 gives 0x40000000 in round mode and 0x3FFFFFFF in truncate mode).
- R4: The sign bit of every non-NaN result is the XOR of the two operand sign bits. This holds for zero and infinity results too.
- R5: A NaN operand (exponent all ones, fraction non-zero), or zero times infinity in either order, returns exactly 0x7FC00000. No other NaN pattern is ever produced.
- R6: Infinity times a non-zero, non-NaN operand returns infinity (0x7F800000 with the sign of R4).
- R7: An operand with a zero exponent field and a non-zero fraction is treated as zero of its own sign. It therefore yields signed zero, or NaN when multiplied by infinity.
- R8: When the biased exponent of the result, after rounding, reaches 255 or more, the result is signed infinity.
- R9: When the biased exponent of the result, after rounding, is 0 or less, the result is signed zero. An output with a zero exponent field and a non-zero fraction never appears.
- R10: Every accepted operand pair (`in_valid` and `in_ready` high at a clock edge) yields exactly one result, in acceptance order, two edges later if the output is not stalled. While `out_valid` is high and `out_ready` is low, `out_res` holds steady and `in_ready` drops once both stages are full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | 32 | First operand, binary32 |
| in_b | input | 32 | Second operand, binary32 |
| rnd_trunc | input | 1 | 0: round to nearest, ties away; 1: truncate toward zero |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 32 | Product, binary32 |

## Verification
A wrong classification latched in the first stage appears at `out_res` two edges after acceptance. It shows as a wrong special pattern, for example a NaN where an infinity belongs, or a stray sign bit. A wrong normalization select or guard bit shows in the last one or two mantissa bits. The tie and carry vectors are chosen so that each rounding path gives a different word in each mode. A slip in the stall logic shows up as a dropped, repeated or reordered result, or as `out_res` changing while the consumer is holding off. The backpressure scenario watches `out_res` and `in_ready` cycle by cycle to catch this.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fpm_cls_e;

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word,
    output logic                 sign,
    output logic [EXP_W-1:0]     exp_f,
    output logic [MAN_W:0]       sig,
    output fpm_cls_e             cls
);
    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

    logic [MAN_W-1:0] frac;

    always_comb begin
        sign  = word[EXP_W+MAN_W];
        exp_f = word[EXP_W+MAN_W-1:MAN_W];
        frac  = word[MAN_W-1:0];
        sig   = {1'b1, frac};
        if (exp_f == '0) begin
            cls = CLS_ZERO;            // subnormals flushed, sign kept
        end else if (exp_f == EXP_ONES) begin
            cls = (frac == '0) ? CLS_INF : CLS_NAN;
        end else begin
            cls = CLS_NUM;
        end
    end

endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                     sign,
    input  fpm_cls_e                 cls,
    input  logic signed [EXP_W+1:0]  exp_sum,
    input  logic [2*MAN_W+1:0]       prod,
    input  logic                     trunc,
    output logic [EXP_W+MAN_W:0]     word
);
    localparam int PW = 2*MAN_W + 2;
    localparam int EW2 = EXP_W + 2;
    localparam logic signed [EW2-1:0] EXP_TOP = EW2'((1 << EXP_W) - 1);
    localparam logic [EXP_W+MAN_W:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic                  hi;
    logic [MAN_W-1:0]      mant_n;
    logic                  guard;
    logic                  up;
    logic [MAN_W:0]        rsum;
    logic signed [EW2-1:0] exp_n;
    logic signed [EW2-1:0] exp_r;

    always_comb begin
        hi     = prod[PW-1];
        mant_n = hi ? prod[PW-2 -: MAN_W] : prod[PW-3 -: MAN_W];
        guard  = hi ? prod[PW-2-MAN_W]    : prod[PW-3-MAN_W];
        exp_n  = exp_sum + EW2'(hi);
        up     = !trunc && guard;
        rsum   = {1'b0, mant_n} + (MAN_W+1)'(up);
        exp_r  = exp_n + EW2'(rsum[MAN_W]);

        unique case (cls)
            CLS_NAN:  word = QNAN;
            CLS_INF:  word = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            CLS_ZERO: word = {sign, {(EXP_W+MAN_W){1'b0}}};
            default: begin
                if (exp_r >= EXP_TOP) begin
                    word = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
                end else if (exp_r <= 0) begin
                    word = {sign, {(EXP_W+MAN_W){1'b0}}};
                end else begin
                    word = {sign, exp_r[EXP_W-1:0], rsum[MAN_W-1:0]};
                end
            end
        endcase
    end

endmodule

// File: rtl/fp32_mul_unit.sv
module fp32_mul_unit
    import fpm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [EXP_W+MAN_W:0]   in_a,
    input  logic [EXP_W+MAN_W:0]   in_b,
    input  logic                   rnd_trunc,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [EXP_W+MAN_W:0]   out_res
);
    localparam int W    = EXP_W + MAN_W + 1;
    localparam int PW   = 2*MAN_W + 2;
    localparam int EW2  = EXP_W + 2;
    localparam int BIAS = (1 << (EXP_W-1)) - 1;
    localparam logic [W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    typedef struct packed {
        logic                  s1_v;
        logic                  s1_sign;
        fpm_cls_e              s1_cls;
        logic signed [EW2-1:0] s1_exp;
        logic [PW-1:0]         s1_prod;
        logic                  s1_trunc;
        logic                  o_v;
        logic [W-1:0]          o_res;
    } pipe_t;

    pipe_t st_d, st_q;

    logic                 sgn [2];
    logic [EXP_W-1:0]     ef  [2];
    logic [MAN_W:0]       sg  [2];
    fpm_cls_e             cl  [2];
    logic [W-1:0]         opw [2];
    logic [W-1:0]         packed_res;
    logic                 advance;

    assign opw[0] = in_a;
    assign opw[1] = in_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fpm_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) unpack_i (
            .word  (opw[gi]),
            .sign  (sgn[gi]),
            .exp_f (ef[gi]),
            .sig   (sg[gi]),
            .cls   (cl[gi])
        );
    end

    fpm_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) round_i (
        .sign    (st_q.s1_sign),
        .cls     (st_q.s1_cls),
        .exp_sum (st_q.s1_exp),
        .prod    (st_q.s1_prod),
        .trunc   (st_q.s1_trunc),
        .word    (packed_res)
    );

    always_comb begin
        advance = !st_q.o_v || out_ready;
        st_d    = st_q;
        if (advance) begin
            st_d.o_v   = st_q.s1_v;
            st_d.o_res = packed_res;
            st_d.s1_v  = in_valid;
            if (in_valid) begin
                st_d.s1_sign  = sgn[0] ^ sgn[1];
                st_d.s1_trunc = rnd_trunc;
                st_d.s1_prod  = sg[0] * sg[1];
                st_d.s1_exp   = $signed({2'b00, ef[0]}) + $signed({2'b00, ef[1]})
                              - EW2'(BIAS);
                if (cl[0] == CLS_NAN || cl[1] == CLS_NAN ||
                    (cl[0] == CLS_ZERO && cl[1] == CLS_INF) ||
                    (cl[0] == CLS_INF && cl[1] == CLS_ZERO)) begin
                    st_d.s1_cls = CLS_NAN;
                end else if (cl[0] == CLS_INF || cl[1] == CLS_INF) begin
                    st_d.s1_cls = CLS_INF;
                end else if (cl[0] == CLS_ZERO || cl[1] == CLS_ZERO) begin
                    st_d.s1_cls = CLS_ZERO;
                end else begin
                    st_d.s1_cls = CLS_NUM;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = advance;
    assign out_valid = st_q.o_v;
    assign out_res   = st_q.o_res;

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_res)); // R10

    AST_ACCEPT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> st_q.s1_v); // R10

    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_res[W-2 -: EXP_W] == {EXP_W{1'b1}}) &&
        (out_res[MAN_W-1:0] != '0) |-> out_res == QNAN); // R5

    AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !((out_res[W-2 -: EXP_W] == '0) &&
                        (out_res[MAN_W-1:0] != '0))); // R9

endmodule

// File: tb/fp32_mul_unit_tb_top.sv
`timescale 1ns/1ps
module fp32_mul_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        rnd_trunc = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_res;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fp32_mul_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .rnd_trunc (rnd_trunc),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_res   (out_res)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic mul_one(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic trunc, input logic [31:0] exp);
        int lat;
        @(negedge clk);
        in_valid  = 1'b1;
        in_a      = a;
        in_b      = b;
        rnd_trunc = trunc;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk({tag, " R10 latency"}, 32'(lat), 32'd2);
        chk(tag, out_res, exp);
    endtask

    task automatic t_reset;
        chk("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10 reset in_ready", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_rounding;
        mul_one("R1 plain 1.5x2", 32'h3FC00000, 32'h40000000, 1'b0, 32'h40400000);
        mul_one("R1 tie away", 32'h3FC00000, 32'h3F800001, 1'b0, 32'h3FC00002);
        mul_one("R2 tie truncated", 32'h3FC00000, 32'h3F800001, 1'b1, 32'h3FC00001);
        mul_one("R1 R4 negative tie away", 32'hBFC00000, 32'h3F800001, 1'b0, 32'hBFC00002);
        mul_one("R2 R4 negative truncated", 32'hBFC00000, 32'h3F800001, 1'b1, 32'hBFC00001);
    endtask

    task automatic t_carry;
        mul_one("R3 carry to 2.0", 32'h3FFFF800, 32'h3F800400, 1'b0, 32'h40000000);
        mul_one("R3 no carry truncated", 32'h3FFFF800, 32'h3F800400, 1'b1, 32'h3FFFFFFF);
        mul_one("R3 R8 carry overflows", 32'h7F7FF800, 32'h3F800400, 1'b0, 32'h7F800000);
        mul_one("R8 truncated max finite", 32'h7F7FF800, 32'h3F800400, 1'b1, 32'h7F7FFFFF);
    endtask

    task automatic t_range;
        mul_one("R8 overflow", 32'h7F000000, 32'h40800000, 1'b0, 32'h7F800000);
        mul_one("R8 R4 negative overflow", 32'hFF000000, 32'h40800000, 1'b0, 32'hFF800000);
        mul_one("R9 underflow", 32'h00800000, 32'h3F000000, 1'b0, 32'h00000000);
        mul_one("R9 R4 negative underflow", 32'h80800000, 32'h3F000000, 1'b0, 32'h80000000);
        mul_one("R9 min normal kept", 32'h00800000, 32'h3F800000, 1'b0, 32'h00800000);
    endtask

    task automatic t_special;
        mul_one("R7 subnormal as zero", 32'h00000001, 32'h40000000, 1'b0, 32'h00000000);
        mul_one("R7 R4 negative subnormal", 32'h80000001, 32'h40000000, 1'b0, 32'h80000000);
        mul_one("R7 R5 subnormal times inf", 32'h007FFFFF, 32'h7F800000, 1'b0, 32'h7FC00000);
        mul_one("R5 nan operand", 32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000);
        mul_one("R5 nan second operand", 32'h3F800000, 32'hFFFFFFFF, 1'b1, 32'h7FC00000);
        mul_one("R5 inf times zero", 32'hFF800000, 32'h00000000, 1'b0, 32'h7FC00000);
        mul_one("R6 R4 inf times -2", 32'h7F800000, 32'hC0000000, 1'b0, 32'hFF800000);
        mul_one("R6 R4 -inf times -inf", 32'hFF800000, 32'hFF800000, 1'b0, 32'h7F800000);
        mul_one("R4 -0 times 3", 32'h80000000, 32'h40400000, 1'b0, 32'h80000000);
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_a      = 32'h40000000;
        in_b      = 32'h40400000;   // 6.0
        rnd_trunc = 1'b0;
        @(negedge clk);
        in_a = 32'hC0800000;
        in_b = 32'h3F000000;        // -2.0
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 full pipe blocks input", {31'd0, in_ready}, 32'd0);
        chk("R10 first result valid", {31'd0, out_valid}, 32'd1);
        for (int i = 0; i < 3; i++) begin
            chk("R10 held result", out_res, 32'h40C00000);
            @(negedge clk);
        end
        chk("R10 held after stall", out_res, 32'h40C00000);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R10 second in order", out_res, 32'hC0000000);
        chk("R10 second valid", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        chk("R10 drained", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_rounding();
        t_carry();
        t_range();
        t_special();
        t_backpressure();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule